// File: doc/BRIEF.md
# Balanced Ternary Ripple Adder

This block adds two signed balanced-ternary words and a carry trit and returns a sum word and a carry trit. Every digit (trit) takes one of the values -1, 0 or +1 and travels on a pair of binary wires. The adder is purely combinational. It is a chain of one-trit full adders, and each stage hands its carry trit to the next more significant stage.

Each one-trit full adder is built from two half adders and a carry merge. All three are networks of three-way multiplexers, and one input trit steers each multiplexer. The block checks every input trit for the one pair that carries no value. If it finds one, it raises an error flag and forces every output trit to zero. Downstream logic therefore never sees a malformed code.

With the default width of 6 trits, a word covers -364 to +364. A result outside that range appears only as a nonzero carry-out trit.

Top module: `tern_ripple_add`

## Requirements
- R1: Each trit occupies two bits, with -1 = 2'b10, 0 = 2'b00 and +1 = 2'b01. Trit k of a word sits in bits [2k+1:2k], and trit 0 is the least significant (weight 1).
- R2: A single stage (N_TRITS = 1) gives s + 3*c = a + b + cin for all 27 legal input combinations, with s and c each in {-1, 0, +1}.
- R3: No output trit ever carries the code 2'b11.
- R4: For legal inputs, value(sum_o) + 3^N_TRITS * value(cout_o) equals value(a_i) + value(b_i) + value(cin_i).
- R5: When the true total lies within the word range (magnitude at most (3^N_TRITS-1)/2), cout_o is the 0 code.
- R6: The code 2'b11 in any trit of a_i, b_i or cin_i sets err_o to 1.
- R7: While err_o is 1, every trit of sum_o and cout_o is the 0 code.
- R8: err_o is 0 whenever all input trits are legal.
- R9: A carry ripples through every stage. For example, all-(+1) plus zero plus a carry-in of +1 gives all-(-1) with a carry-out of +1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 2*N_TRITS | First operand, two bits per trit |
| b_i | input | 2*N_TRITS | Second operand, two bits per trit |
| cin_i | input | 2 | Carry-in trit |
| sum_o | output | 2*N_TRITS | Sum word |
| cout_o | output | 2 | Carry-out trit |
| err_o | output | 1 | Illegal input code seen |

## Verification
The cases the bench targets are the saturated operands, where a carry has to cross every stage, and the sums that exceed the range by exactly one, where the sum word wraps to the opposite extreme. A design that drops a stage's carry, or that merges the two half-adder carries with a plain OR, produces either a wrong low trit or the illegal 11 code on the carry. The bench also places an illegal code in each operand trit position and in the carry-in. A design that checks only some positions, or that does not force the outputs to zero, leaks garbage sums or leaves the flag low.

// File: rtl/tern_pkg.sv
package tern_pkg;
  typedef logic [1:0] trit_t;

  localparam trit_t T_NEG = 2'b10;
  localparam trit_t T_ZER = 2'b00;
  localparam trit_t T_POS = 2'b01;
  localparam trit_t T_BAD = 2'b11;

  // three-way select steered by one trit
  function automatic trit_t tmux(trit_t sel, trit_t on_neg, trit_t on_zer, trit_t on_pos);
    case (sel)
      T_NEG:   return on_neg;
      T_POS:   return on_pos;
      default: return on_zer;
    endcase
  endfunction

  function automatic trit_t cyc_up(trit_t t);
    return tmux(t, T_ZER, T_POS, T_NEG);
  endfunction

  function automatic trit_t cyc_dn(trit_t t);
    return tmux(t, T_POS, T_NEG, T_ZER);
  endfunction
endpackage

// File: rtl/tern_half_add.sv
module tern_half_add
  import tern_pkg::*;
(
  input  trit_t x_i,
  input  trit_t y_i,
  output trit_t s_o,
  output trit_t c_o
);
  trit_t c_neg, c_pos;

  always_comb begin
    c_neg = (y_i == T_NEG) ? T_NEG : T_ZER;
    c_pos = (y_i == T_POS) ? T_POS : T_ZER;
    s_o   = tmux(x_i, cyc_dn(y_i), y_i, cyc_up(y_i));
    c_o   = tmux(x_i, c_neg, T_ZER, c_pos);
  end
endmodule

// File: rtl/tern_full_add.sv
module tern_full_add
  import tern_pkg::*;
(
  input  trit_t a_i,
  input  trit_t b_i,
  input  trit_t c_i,
  output trit_t s_o,
  output trit_t c_o
);
  trit_t s_ab, c_ab, c_sc;

  tern_half_add u_ha_ab (.x_i(a_i),  .y_i(b_i), .s_o(s_ab), .c_o(c_ab));
  tern_half_add u_ha_sc (.x_i(s_ab), .y_i(c_i), .s_o(s_o),  .c_o(c_sc));

  // c_ab and c_sc never share a sign; opposite signs cancel
  always_comb begin
    c_o = tmux(c_ab,
               (c_sc == T_POS) ? T_ZER : T_NEG,
               c_sc,
               (c_sc == T_NEG) ? T_ZER : T_POS);
  end
endmodule

// File: rtl/tern_illegal_det.sv
module tern_illegal_det
  import tern_pkg::*;
#(
  parameter int N_CODES = 13
) (
  input  logic [2*N_CODES-1:0] codes_i,
  output logic                 bad_o
);
  logic [N_CODES-1:0] hit;

  for (genvar k = 0; k < N_CODES; k++) begin : g_code
    assign hit[k] = (codes_i[2*k +: 2] == T_BAD);
  end

  assign bad_o = |hit;
endmodule

// File: rtl/tern_ripple_add.sv
module tern_ripple_add
  import tern_pkg::*;
#(
  parameter int N_TRITS = 6
) (
  input  logic [2*N_TRITS-1:0] a_i,
  input  logic [2*N_TRITS-1:0] b_i,
  input  logic [1:0]           cin_i,
  output logic [2*N_TRITS-1:0] sum_o,
  output logic [1:0]           cout_o,
  output logic                 err_o
);
  localparam int W      = 2 * N_TRITS;
  localparam int N_CODE = 2 * N_TRITS + 1;

  trit_t          carry [N_TRITS+1];
  logic [W-1:0]   sum_raw;
  logic           bad;

  assign carry[0] = cin_i;

  for (genvar k = 0; k < N_TRITS; k++) begin : g_stage
    tern_full_add u_fa (
      .a_i (a_i[2*k +: 2]),
      .b_i (b_i[2*k +: 2]),
      .c_i (carry[k]),
      .s_o (sum_raw[2*k +: 2]),
      .c_o (carry[k+1])
    );
  end

  tern_illegal_det #(.N_CODES(N_CODE)) u_det (
    .codes_i ({cin_i, b_i, a_i}),
    .bad_o   (bad)
  );

  assign err_o  = bad;
  assign sum_o  = bad ? '0 : sum_raw;
  assign cout_o = bad ? T_ZER : carry[N_TRITS];
endmodule

// File: rtl/tern_ripple_add_chk.sv
module tern_ripple_add_chk #(
  parameter int N_TRITS = 6
) (
  input logic [2*N_TRITS-1:0] a_i,
  input logic [2*N_TRITS-1:0] b_i,
  input logic [1:0]           cin_i,
  input logic [2*N_TRITS-1:0] sum_o,
  input logic [1:0]           cout_o,
  input logic                 err_o
);
  function automatic int tval(logic [1:0] t);
    return (t == 2'b01) ? 1 : (t == 2'b10) ? -1 : 0;
  endfunction

  function automatic int wval(logic [2*N_TRITS-1:0] w);
    int acc = 0;
    int wt  = 1;
    for (int k = 0; k < N_TRITS; k++) begin
      acc += wt * tval(w[2*k +: 2]);
      wt  *= 3;
    end
    return acc;
  endfunction

  function automatic bit has_bad(logic [2*N_TRITS-1:0] w);
    for (int k = 0; k < N_TRITS; k++)
      if (w[2*k +: 2] == 2'b11) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int span();
    int p = 1;
    for (int k = 0; k < N_TRITS; k++) p *= 3;
    return p;
  endfunction

  logic in_bad;
  int   total;
  int   half;

  always_comb begin
    in_bad = has_bad(a_i) || has_bad(b_i) || (cin_i == 2'b11);
    total  = wval(a_i) + wval(b_i) + tval(cin_i);
    half   = (span() - 1) / 2;
    AST_LEGAL_OUT: assert (!has_bad(sum_o) && cout_o != 2'b11); // R3
    AST_SUM_VALUE: assert (in_bad || (wval(sum_o) + span() * tval(cout_o) == total)); // R4
    AST_NO_OVERFLOW: assert (in_bad || total > half || total < -half || cout_o == 2'b00); // R5
    AST_ERR_SEEN: assert (!in_bad || err_o); // R6
    AST_ERR_ZERO: assert (!err_o || (sum_o == '0 && cout_o == 2'b00)); // R7
    AST_ERR_QUIET: assert (in_bad || !err_o); // R8
  end
endmodule

bind tern_ripple_add tern_ripple_add_chk #(.N_TRITS(N_TRITS)) chk_i (.*);

// File: tb/tern_ripple_add_tb_top.sv
module tern_ripple_add_tb_top;
  localparam int N   = 6;
  localparam int W   = 2 * N;
  localparam int SPAN = 729;
  localparam int NV  = 10;
  // {a, b, cin, expected sum, expected cout}
  localparam int VEC [NV][5] = '{
    '{   0,    0,  0,    0,  0},
    '{   1,    1,  0,    2,  0},
    '{ 364,    0,  1, -364,  1},
    '{-364,    0, -1,  364, -1},
    '{ 364,  364,  1,    0,  1},
    '{-364, -364, -1,    0, -1},
    '{ 100, -100,  0,    0,  0},
    '{ 121,  122,  1,  244,  0},
    '{ 200,  200,  0, -329,  1},
    '{  -5,    3,  1,   -1,  0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] a, b, sum;
  logic [1:0]   cin, cout;
  logic         err;
  logic [1:0]   fa_a, fa_b, fa_c, fa_s, fa_co;
  logic         fa_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  tern_ripple_add #(.N_TRITS(N)) dut_i (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout), .err_o(err));

  tern_ripple_add #(.N_TRITS(1)) fa_i (
    .a_i(fa_a), .b_i(fa_b), .cin_i(fa_c), .sum_o(fa_s), .cout_o(fa_co), .err_o(fa_err));

  function automatic logic [1:0] t_enc(int v);
    return (v > 0) ? 2'b01 : (v < 0) ? 2'b10 : 2'b00;
  endfunction

  function automatic int t_dec(logic [1:0] t);
    return (t == 2'b01) ? 1 : (t == 2'b10) ? -1 : (t == 2'b00) ? 0 : 99;
  endfunction

  function automatic logic [W-1:0] w_enc(int v);
    logic [W-1:0] w = '0;
    int r;
    for (int k = 0; k < N; k++) begin
      r = ((v % 3) + 3) % 3;
      if (r == 2) begin w[2*k +: 2] = 2'b10; v = (v + 1) / 3; end
      else if (r == 1) begin w[2*k +: 2] = 2'b01; v = (v - 1) / 3; end
      else v = v / 3;
    end
    return w;
  endfunction

  function automatic int w_dec(logic [W-1:0] w);
    int acc = 0;
    int wt = 1;
    for (int k = 0; k < N; k++) begin
      acc += wt * t_dec(w[2*k +: 2]);
      wt *= 3;
    end
    return acc;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(int av, int bv, int cv);
    @(posedge clk);
    a = w_enc(av); b = w_enc(bv); cin = t_enc(cv);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    a = '0; b = '0; cin = '0;
    fa_a = '0; fa_b = '0; fa_c = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // idle state: zero in gives zero out, no error (R1, R8)
    check(sum == '0 && cout == 2'b00, "R1 idle", int'(sum), 0);
    check(!err, "R8 idle", int'(err), 0);

    // R2: exhaustive single stage
    for (int x = -1; x <= 1; x++)
      for (int y = -1; y <= 1; y++)
        for (int z = -1; z <= 1; z++) begin
          @(posedge clk);
          fa_a = t_enc(x); fa_b = t_enc(y); fa_c = t_enc(z);
          @(negedge clk);
          check(t_dec(fa_s) + 3 * t_dec(fa_co) == x + y + z && !fa_err,
                "R2 stage", t_dec(fa_s) + 3 * t_dec(fa_co), x + y + z);
          check(fa_s != 2'b11 && fa_co != 2'b11, "R3 stage code", int'(fa_s), 0);
        end

    // table walk (R4, R5, R9)
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][0], VEC[i][1], VEC[i][2]);
      check(w_dec(sum) == VEC[i][3], "R4 table sum", w_dec(sum), VEC[i][3]);
      check(t_dec(cout) == VEC[i][4], "R9 table carry", t_dec(cout), VEC[i][4]);
    end

    // R9: full ripple, all +1 plus carry-in
    apply(364, 0, 1);
    check(sum == {N{2'b10}}, "R9 ripple", w_dec(sum), -364);

    // random against integer reference
    for (int i = 0; i < 400; i++) begin
      int av, bv, cv, tot, es, ec;
      av = int'($urandom_range(0, 728)) - 364;
      bv = int'($urandom_range(0, 728)) - 364;
      cv = int'($urandom_range(0, 2)) - 1;
      tot = av + bv + cv;
      ec = (tot > 364) ? 1 : (tot < -364) ? -1 : 0;
      es = tot - SPAN * ec;
      apply(av, bv, cv);
      check(w_dec(sum) == es, "R4 random sum", w_dec(sum), es);
      check(t_dec(cout) == ec, "R5 random carry", t_dec(cout), ec);
      check(!err, "R8 random", int'(err), 0);
    end

    // R6, R7: illegal code in each trit position
    for (int k = 0; k < 2 * N + 1; k++) begin
      apply(121, -200, 1);
      @(posedge clk);
      if (k < N) a[2*k +: 2] = 2'b11;
      else if (k < 2 * N) b[2*(k-N) +: 2] = 2'b11;
      else cin = 2'b11;
      @(negedge clk);
      check(err, "R6 flag", int'(err), 1);
      check(sum == '0 && cout == 2'b00, "R7 zeroed", int'(sum), 0);
    end

    // R6, R7 on single stage
    @(posedge clk);
    fa_a = 2'b01; fa_b = 2'b11; fa_c = 2'b01;
    @(negedge clk);
    check(fa_err && fa_s == 2'b00 && fa_co == 2'b00, "R7 stage", int'(fa_s), 0);

    // error clears once inputs legal again (R8)
    apply(1, 1, 1);
    check(!err && w_dec(sum) == 3, "R8 recover", w_dec(sum), 3);

    finish_run();
  end
endmodule